// File: doc/BRIEF.md
# Converter Serial Readout Port

This block models the device side of a 16-bit converter's serial output when the converter is used with a three-wire chip-select scheme: one convert/select line, one serial clock from the host, and a data line the device drives or releases. A rising edge on the convert line starts a conversion when the data-in pin is high. The conversion is timed internally by a counter of system clocks and always runs to its end, whatever the convert line does in the meantime. At the end of the conversion, the block captures the supplied sample word and holds it for readout.

Lowering the convert line after the result is ready enables the output and places the most significant bit on it. Each falling edge of the serial clock then moves the next bit out. The output is released after the sixteenth falling edge, or sooner if the convert line rises. The block is meant to be a self-checking target for a host-side sequencer. The convert, serial clock and data-in pins are asynchronous to the system clock, so each passes through a two-stage synchronizer, and edges are detected on the synchronized levels. Every pin action therefore takes effect on the third rising system-clock edge after the pin changes. The sample word is a plain level input with no handshake, and it is read only in the cycle in which a conversion completes.

Top module: `conv_serial_out`

## Requirements
- R1: While reset is held and directly after it, `dout_oe`, `dout` and `conv_active` are all 0.
- R2: A convert-line rising edge with `din_level` high sets `conv_active` for exactly CONV_CYCLES system clocks (default 40). A rising edge with `din_level` low starts no conversion.
- R3: Once started, a conversion keeps `conv_active` high for its full length and `dout_oe` low, even if the convert line falls or rises again during it.
- R4: `sample_word` is captured in the completion cycle only. Later changes to it do not alter the bits that are read out.
- R5: A convert-line falling edge while a result is waiting sets `dout_oe` and puts bit 15 of the captured word on `dout`.
- R6: Each serial-clock falling edge while `dout_oe` is high moves the next lower bit onto `dout`, so the word comes out MSB first over 16 bits.
- R7: The sixteenth serial-clock falling edge clears `dout_oe`, and further serial-clock edges leave it low.
- R8: A convert-line rising edge clears `dout_oe` at once, even in the middle of a frame and even in the same cycle as a serial-clock falling edge.
- R9: If the convert line is low when a conversion completes, `dout_oe` rises at completion with bit 15 on `dout`.
- R10: `dout` is 0 whenever `dout_oe` is 0.
- R11: A convert-line falling edge when no unread result is waiting leaves `dout_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| convert_pin | input | 1 | Convert / chip-select line from the host (asynchronous) |
| sclk_pin | input | 1 | Serial clock from the host (asynchronous) |
| din_level | input | 1 | Data-in pin level; must be high for a rise to start a conversion |
| sample_word | input | DATA_W | Word captured when a conversion completes |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Output enable; 0 means the line is released |
| conv_active | output | 1 | High while a conversion is running |

## Verification
Two functions can land in the same cycle. A convert-line rise that releases the output and starts a new conversion can arrive together with a serial-clock falling edge that would shift a bit. The bench provokes this by changing both pins in the same step in the middle of a frame, after reading five bits, and it judges the result by requiring `dout_oe` to be low and `dout` to be 0 afterwards. The bench also lets a conversion complete while the convert line is already low, where completion and the output enable coincide, and it checks that the MSB is present at once without a falling edge.

// File: rtl/sercv_pkg.sv
package sercv_pkg;
  localparam int PIN_CVT  = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_DIN  = 2;
  localparam int NUM_PINS = 3;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_ev_t;
endpackage

// File: rtl/sercv_pin_sync.sv
module sercv_pin_sync #(
  parameter int NSIG   = 3,
  parameter int STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NSIG-1:0]                   pins,
  output sercv_pkg::pin_ev_t [NSIG-1:0]     ev
);
  for (genvar g = 0; g < NSIG; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], pins[g]};
        last  <= chain[STAGES-1];
      end
    end

    assign ev[g].lvl  = chain[STAGES-1];
    assign ev[g].rise = chain[STAGES-1] & ~last;
    assign ev[g].fall = ~chain[STAGES-1] & last;
  end
endmodule

// File: rtl/sercv_conv_timer.sv
module sercv_conv_timer #(
  parameter int CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start_req) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end
  end

  assign done = busy && (cnt == '0);

  assert_runs_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  assert_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_start_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req) |=> (busy && cnt == LOAD));
endmodule

// File: rtl/sercv_out_shifter.sv
module sercv_out_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cvt_rise,
  input  logic              cvt_fall,
  input  logic              cvt_lvl,
  input  logic              sclk_fall,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] sample_word,
  output logic              dout,
  output logic              dout_oe
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bits;
  logic              en;
  logic              avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      bits  <= '0;
      en    <= 1'b0;
      avail <= 1'b0;
    end else if (cvt_rise) begin
      en    <= 1'b0;
      avail <= 1'b0;
    end else if (conv_done) begin
      shreg <= sample_word;
      bits  <= '0;
      avail <= 1'b1;
      en    <= ~cvt_lvl;
    end else if (en && sclk_fall) begin
      shreg <= {shreg[DATA_W-2:0], 1'b0};
      if (bits == LAST) begin
        en    <= 1'b0;
        avail <= 1'b0;
      end else begin
        bits <= bits + 1'b1;
      end
    end else if (cvt_fall && avail && !en) begin
      en <= 1'b1;
    end
  end

  assign dout_oe = en;
  assign dout    = en & shreg[DATA_W-1];

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cvt_rise |=> !dout_oe);

  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sclk_fall && bits == LAST && !cvt_rise) |=> !dout_oe);

  assert_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sclk_fall && bits != LAST && !cvt_rise && !conv_done)
      |=> (dout_oe && dout == $past(shreg[DATA_W-2])));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !cvt_rise) |=> shreg == $past(sample_word));

  assert_no_redrive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !avail && !conv_done) |=> !dout_oe);

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dout_oe) |-> !dout);
endmodule

// File: rtl/conv_serial_out.sv
module conv_serial_out #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convert_pin,
  input  logic              sclk_pin,
  input  logic              din_level,
  input  logic [DATA_W-1:0] sample_word,
  output logic              dout,
  output logic              dout_oe,
  output logic              conv_active
);
  import sercv_pkg::*;

  pin_ev_t [NUM_PINS-1:0] ev;
  logic [NUM_PINS-1:0]    pins;
  logic                   start_req;
  logic                   conv_done;

  assign pins[PIN_CVT]  = convert_pin;
  assign pins[PIN_SCLK] = sclk_pin;
  assign pins[PIN_DIN]  = din_level;

  sercv_pin_sync #(.NSIG(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pins (pins),
    .ev   (ev)
  );

  assign start_req = ev[PIN_CVT].rise & ev[PIN_DIN].lvl;

  sercv_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .busy     (conv_active),
    .done     (conv_done)
  );

  sercv_out_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .cvt_rise   (ev[PIN_CVT].rise),
    .cvt_fall   (ev[PIN_CVT].fall),
    .cvt_lvl    (ev[PIN_CVT].lvl),
    .sclk_fall  (ev[PIN_SCLK].fall),
    .conv_done  (conv_done),
    .sample_word(sample_word),
    .dout       (dout),
    .dout_oe    (dout_oe)
  );

  assert_quiet_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && !conv_done) |-> !dout_oe);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!dout_oe && !conv_active));
endmodule

// File: tb/tb_conv_serial_out.sv
`timescale 1ns/1ps
module tb_conv_serial_out;
  localparam int W    = 16;
  localparam int CONV = 40;
  localparam int SET  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cvt = 1'b0, sclk = 1'b0, din = 1'b1;
  logic [W-1:0] sample = '0;
  logic dout, dout_oe, conv_active;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] got_q[$];

  always #2.5 clk = ~clk;

  conv_serial_out #(.DATA_W(W), .CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst_n(rst_n), .convert_pin(cvt), .sclk_pin(sclk),
    .din_level(din), .sample_word(sample), .dout(dout),
    .dout_oe(dout_oe), .conv_active(conv_active)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: compares every captured frame with the next expected word
  initial begin
    forever begin
      logic [W-1:0] g, e;
      wait (got_q.size() != 0);
      g = got_q.pop_front();
      e = (exp_q.size() != 0) ? exp_q.pop_front() : ~g;
      check("R6 frame word", 32'(g), 32'(e));
    end
  end

  // Driver: clock a full frame out, pushing expected and captured words
  task automatic read_frame(logic [W-1:0] expw, bit do_fall);
    logic [W-1:0] acc = '0;
    exp_q.push_back(expw);
    if (do_fall) begin
      cvt = 1'b0;
      tick(SET);
    end
    check("R5 oe after fall", 32'(dout_oe), 32'd1);
    for (int i = W - 1; i >= 0; i--) begin
      acc[i] = dout;
      sclk = 1'b1; tick(SET);
      sclk = 1'b0; tick(SET);
    end
    got_q.push_back(acc);
    check("R7 released after last bit", 32'(dout_oe), 32'd0);
  endtask

  task automatic convert(logic [W-1:0] w, output int busy_cnt);
    sample = w;
    busy_cnt = 0;
    cvt = 1'b1;
    for (int i = 0; i < CONV + 10; i++) begin
      tick(1);
      if (conv_active) busy_cnt++;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    int bc;
    logic [W-1:0] part;
    tick(3);
    check("R1 oe in reset", 32'(dout_oe), 32'd0);
    check("R1 busy in reset", 32'(conv_active), 32'd0);
    rst_n = 1'b1;
    tick(2);
    check("R1 oe after reset", 32'(dout_oe), 32'd0);
    check("R10 dout idle", 32'(dout), 32'd0);

    // R2: rise with data-in low starts nothing; R11: fall gives nothing
    din = 1'b0; cvt = 1'b1; tick(SET + 2);
    check("R2 no start din low", 32'(conv_active), 32'd0);
    cvt = 1'b0; tick(SET);
    check("R11 no result no drive", 32'(dout_oe), 32'd0);
    din = 1'b1; tick(2);

    // R2 / R4 / R5 / R6 / R7
    convert(16'hA5C3, bc);
    check("R2 busy length", 32'(bc), 32'(CONV));
    sample = 16'h0000;
    read_frame(16'hA5C3, 1'b1);
    sclk = 1'b1; tick(SET); sclk = 1'b0; tick(SET);
    check("R7 stays released", 32'(dout_oe), 32'd0);
    check("R10 dout low when off", 32'(dout), 32'd0);

    // R11: second fall without a new conversion
    din = 1'b0; cvt = 1'b1; tick(SET); cvt = 1'b0; tick(SET);
    check("R11 no redrive", 32'(dout_oe), 32'd0);
    din = 1'b1; tick(2);

    // R3: convert line toggles during conversion
    sample = 16'h3C5A;
    bc = 0;
    cvt = 1'b1;
    for (int i = 0; i < CONV + 10; i++) begin
      if (i == 8)  cvt = 1'b0;
      if (i == 16) cvt = 1'b1;
      if (i == 20) check("R3 oe low during conv", 32'(dout_oe), 32'd0);
      tick(1);
      if (conv_active) bc++;
    end
    check("R3 busy length with toggles", 32'(bc), 32'(CONV));
    read_frame(16'h3C5A, 1'b1);

    convert(16'hFFFF, bc);
    read_frame(16'hFFFF, 1'b1);
    convert(16'h0001, bc);
    read_frame(16'h0001, 1'b1);

    // R8: early release coinciding with a serial-clock fall
    convert(16'hB00F, bc);
    cvt = 1'b0; tick(SET);
    part = '0;
    for (int i = 0; i < 5; i++) begin
      part[W-1-i] = dout;
      sclk = 1'b1; tick(SET);
      if (i < 4) begin sclk = 1'b0; tick(SET); end
    end
    check("R6 partial bits", 32'(part[W-1 -: 5]), 32'(5'b10110));
    sample = 16'h8001;
    sclk = 1'b0; cvt = 1'b1; tick(SET);
    check("R8 released on rise", 32'(dout_oe), 32'd0);
    check("R10 dout low after release", 32'(dout), 32'd0);

    // R9: the rise above started a conversion; drop the line while busy
    tick(4);
    check("R2 rise restarted conv", 32'(conv_active), 32'd1);
    cvt = 1'b0;
    tick(CONV + 6);
    check("R9 oe at completion", 32'(dout_oe), 32'd1);
    check("R9 msb at completion", 32'(dout), 32'd1);
    read_frame(16'h8001, 1'b0);

    tick(20);
    report();
  end
endmodule